// File: doc/BRIEF.md
# Multichannel Input Capture Timer

A free-running up-counter is shared by four capture channels. The counter runs from the moment reset is released and has no enable. Each channel watches one trigger source: either its own dedicated input pin or one line of a shared input event bus. A qualified edge on that source copies the current count into the channel's measure register. Software then reads the register to timestamp external events or to measure pulse widths and periods.

The count clock is the bus clock divided by two, or the rising edges of an external clock-bus input. Each trigger is resynchronised through two flops before its edge is detected. Each channel has a sticky capture flag with its own interrupt enable. All enabled flags merge onto one interrupt request. A chip can place two instances side by side to get eight channels, each instance with its own counter.

Registers sit on a plain word-addressed port. Writes take effect at the clock edge and reads are combinational.

| Addr | Access | Content |
|------|--------|---------|
| 0 | RW | bit 0 `clk_sel`: 0 = bus clock / 2, 1 = external clock input |
| 1 | R / W1C | bits [N_CH-1:0] capture flags, bit N_CH counter wrap flag |
| 2 | RO | current count |
| 4+c | RW | channel c: bits [1:0] edge mode, bits [2+:SRC_W] source, bit 15 interrupt enable |
| 8+c | RO | channel c measure value |

Top module: `mcap_timer`

## Requirements
- R1: After reset the count is 0. With `clk_sel`=0 it increases by one on every second rising edge of `clk_i`, beginning right after reset release. The first increment lands on the second edge.
- R2: The count wraps from all-ones to 0. At the wrap, status bit N_CH becomes 1 and stays 1 until a 1 is written to that bit.
- R3: With `clk_sel`=1 the count increases by exactly one for each rising edge on `ext_clk_i` and does not change otherwise.
- R4: The edge mode field selects the capture condition: 0 = never, 1 = rising, 2 = falling, 3 = both edges.
- R5: Source value 0 selects the channel's pin `cap_pin_i[c]`. Source value k (1..EVT_W) selects `evt_i[k-1]`. Edges on sources that are not selected cause no capture.
- R6: If the selected source changes before clock edge k, the measure register takes, at edge k+2, the count held between edges k+1 and k+2. This is the value before any increment made at that same edge.
- R7: A capture sets channel flag bit c in status, and the flag stays set. Writing 1 to bit c clears it; writing 0 leaves it set. A capture in the same cycle as a clear wins.
- R8: `irq_o` is high exactly when some channel has both its flag and its interrupt enable set.
- R9: Configuration registers read back what was written. Unmapped addresses read 0.
- R10: A capture on one channel leaves the other channels' measure registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | bus clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| ext_clk_i | input | 1 | external count clock from the clock bus |
| cap_pin_i | input | N_CH | dedicated trigger pin per channel |
| evt_i | input | EVT_W | shared input event bus |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | ADDR_W | register word address |
| reg_wdata_i | input | DATA_W | register write data |
| reg_rdata_o | output | DATA_W | register read data |
| irq_o | output | 1 | merged capture interrupt |

## Verification
The bench builds the block with an 8-bit counter, four channels and four event lines. The narrow counter brings the wrap and its sticky flag within a few hundred clocks, and the bench's own count expectation stays valid across many wraps. The small channel and event counts make a full sweep affordable: every channel, in every edge mode, from every source. Each capture's expected value comes from the number of clock edges since reset.

// File: rtl/mcap_pkg.sv
package mcap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_STAT  = 1;
  localparam int ADDR_CNT   = 2;
  localparam int ADDR_CFG0  = 4;
  localparam int ADDR_MEAS0 = 8;
  localparam int IE_BIT     = 15;
endpackage

// File: rtl/mcap_tick_gen.sv
module mcap_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_sel_i,
  input  logic ext_clk_i,
  output logic tick_o
);
  logic                   div_q;
  logic [SYNC_STAGES-1:0] ext_sync_q;
  logic                   ext_prev_q;
  logic                   ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q      <= 1'b0;
      ext_sync_q <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      div_q      <= ~div_q;
      ext_sync_q <= {ext_sync_q[SYNC_STAGES-2:0], ext_clk_i};
      ext_prev_q <= ext_sync_q[SYNC_STAGES-1];
    end
  end

  assign ext_rise = ext_sync_q[SYNC_STAGES-1] & ~ext_prev_q;
  assign tick_o   = ext_sel_i ? ext_rise : div_q;
endmodule

// File: rtl/mcap_counter.sv
module mcap_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap = tick_i & (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (wrap) ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/mcap_channel.sv
module mcap_channel
  import mcap_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int EVT_W = 4,
  parameter int SRC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [SRC_W-1:0] src_i,
  input  edge_mode_e       mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             flag_o
);
  logic             trig_raw;
  logic [2:0]       sh_q;  // [0],[1] synchronizer, [2] previous level
  logic             rise, fall, hit;
  logic [CNT_W-1:0] meas_q;
  logic             flag_q;

  always_comb begin
    trig_raw = 1'b0;
    if (src_i == '0) trig_raw = pin_i;
    for (int k = 0; k < EVT_W; k++) begin
      if (src_i == SRC_W'(k + 1)) trig_raw = evt_i[k];
    end
  end

  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];

  always_comb begin
    case (mode_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      meas_q <= '0;
      flag_q <= 1'b0;
    end else begin
      sh_q <= {sh_q[1:0], trig_raw};
      if (hit) meas_q <= cnt_i;
      if (hit) flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign meas_o = meas_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/mcap_timer.sv
module mcap_timer
  import mcap_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int N_CH   = 4,
  parameter int EVT_W  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic [N_CH-1:0]   cap_pin_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int SRC_W = $clog2(EVT_W + 1);

  logic                  clk_sel_q;
  edge_mode_e            mode_q [N_CH];
  logic [SRC_W-1:0]      src_q  [N_CH];
  logic [N_CH-1:0]       ie_vec;
  logic [N_CH-1:0]       cap_flag;
  logic [N_CH-1:0]       flag_clr;
  logic [CNT_W-1:0]      meas   [N_CH];
  logic [N_CH*CNT_W-1:0] meas_flat;
  logic [CNT_W-1:0]      cnt;
  logic                  ovf;
  logic                  ovf_clr;
  logic                  tick;
  logic                  stat_wr;
  logic                  unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign stat_wr = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_STAT));
  assign ovf_clr = stat_wr && reg_wdata_i[N_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_sel_q <= 1'b0;
    else if (reg_we_i && (reg_addr_i == ADDR_W'(ADDR_CTRL))) clk_sel_q <= reg_wdata_i[0];
  end

  mcap_tick_gen #(.SYNC_STAGES(2)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_sel_i (clk_sel_q),
    .ext_clk_i (ext_clk_i),
    .tick_o    (tick)
  );

  mcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .ovf_clr_i (ovf_clr),
    .cnt_o     (cnt),
    .ovf_o     (ovf)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic cfg_wr;
    assign cfg_wr      = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_CFG0 + c));
    assign flag_clr[c] = stat_wr && reg_wdata_i[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q[c] <= EDGE_OFF;
        src_q[c]  <= '0;
        ie_vec[c] <= 1'b0;
      end else if (cfg_wr) begin
        mode_q[c] <= edge_mode_e'(reg_wdata_i[1:0]);
        src_q[c]  <= reg_wdata_i[2 +: SRC_W];
        ie_vec[c] <= reg_wdata_i[IE_BIT];
      end
    end

    mcap_channel #(.CNT_W(CNT_W), .EVT_W(EVT_W), .SRC_W(SRC_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (cap_pin_i[c]),
      .evt_i      (evt_i),
      .src_i      (src_q[c]),
      .mode_i     (mode_q[c]),
      .cnt_i      (cnt),
      .flag_clr_i (flag_clr[c]),
      .meas_o     (meas[c]),
      .flag_o     (cap_flag[c])
    );

    assign meas_flat[c*CNT_W +: CNT_W] = meas[c];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADDR_CTRL)) reg_rdata_o[0] = clk_sel_q;
    if (reg_addr_i == ADDR_W'(ADDR_STAT)) begin
      reg_rdata_o[N_CH-1:0] = cap_flag;
      reg_rdata_o[N_CH]     = ovf;
    end
    if (reg_addr_i == ADDR_W'(ADDR_CNT)) reg_rdata_o = DATA_W'(cnt);
    for (int c = 0; c < N_CH; c++) begin
      if (reg_addr_i == ADDR_W'(ADDR_CFG0 + c)) begin
        reg_rdata_o[1:0]        = mode_q[c];
        reg_rdata_o[2 +: SRC_W] = src_q[c];
        reg_rdata_o[IE_BIT]     = ie_vec[c];
      end
      if (reg_addr_i == ADDR_W'(ADDR_MEAS0 + c)) reg_rdata_o = DATA_W'(meas[c]);
    end
  end

  assign irq_o = |(cap_flag & ie_vec);
endmodule

// File: rtl/mcap_timer_chk.sv
module mcap_timer_chk #(
  parameter int CNT_W = 32,
  parameter int N_CH  = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [CNT_W-1:0]      cnt_i,
  input logic                  ovf_i,
  input logic [N_CH-1:0]       flags_i,
  input logic [N_CH-1:0]       ie_i,
  input logic                  irq_i,
  input logic [N_CH*CNT_W-1:0] meas_i
);
  assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i)) |-> (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

  assert_wrap_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(cnt_i) == '1) && (cnt_i == '0)) |-> ovf_i);

  assert_irq_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_i & ie_i) == '0) |-> !irq_i);

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    assert_meas_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (meas_i[c*CNT_W +: CNT_W] != $past(meas_i[c*CNT_W +: CNT_W]))
        |-> (meas_i[c*CNT_W +: CNT_W] == $past(cnt_i)));

    assert_meas_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (meas_i[c*CNT_W +: CNT_W] != $past(meas_i[c*CNT_W +: CNT_W])) |-> flags_i[c]);
  end
endmodule

bind mcap_timer mcap_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt_i   (cnt),
  .ovf_i   (ovf),
  .flags_i (cap_flag),
  .ie_i    (ie_vec),
  .irq_i   (irq_o),
  .meas_i  (meas_flat)
);

// File: tb/tb_mcap_timer.sv
module tb_mcap_timer;
  localparam int CW = 8;
  localparam int NC = 4;
  localparam int EW = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_clk_i = 1'b0;
  logic [NC-1:0] cap_pin_i = '0;
  logic [EW-1:0] evt_i = '0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int total = 0;
  int fails = 0;
  int edges = 0;
  int exp_meas [NC];

  mcap_timer #(.CNT_W(CW), .N_CH(NC), .EVT_W(EW), .DATA_W(32), .ADDR_W(4)) dut (
    .clk_i, .rst_ni, .ext_clk_i, .cap_pin_i, .evt_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) if (rst_ni) edges <= edges + 1;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 4'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr_i = 4'(a);
    #1 d = reg_rdata_o;
  endtask

  function automatic int cnt_now(input int e);
    return (e / 2) % 256;
  endfunction

  task automatic drive_sel(input int c, input int s, input logic v);
    if (s == 0) cap_pin_i[c] = v;
    else evt_i[s-1] = v;
  endtask

  task automatic drive_other(input int c, input int s, input logic v);
    if (s != 0) cap_pin_i[c] = v;
    for (int k = 0; k < EW; k++) if (k != s - 1) evt_i[k] = v;
  endtask

  task automatic chk_others(input int c);
    logic [31:0] d;
    for (int o = 0; o < NC; o++) begin
      if (o != c) begin
        rd(8 + o, d);
        chk("R10 other channel unchanged", d, 32'(exp_meas[o]));
      end
    end
  endtask

  initial begin
    repeat (5000 * 40) @(posedge clk_i);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] c0;
    int e0;
    bit exp_hit;
    for (int c = 0; c < NC; c++) exp_meas[c] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // reset state, before the first edge
    rd(2, d); chk("R1 count zero at reset", d, 0);
    rd(1, d); chk("R7 status clear at reset", d, 0);
    rd(8, d); chk("R6 measure zero at reset", d, 0);
    chk("R8 irq low at reset", 32'(irq_o), 0);

    // free-running bus/2 count
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i);
      rd(2, d); chk("R1 count follows edges/2", d, 32'(cnt_now(edges)));
    end

    // wrap and sticky overflow
    rd(1, d); chk("R2 no wrap yet", 32'(d[NC]), 0);
    while (edges < 515) @(negedge clk_i);
    rd(1, d); chk("R2 wrap flag set", 32'(d[NC]), 1);
    rd(2, d); chk("R1 R2 count after wrap", d, 32'(cnt_now(edges)));
    repeat (6) @(negedge clk_i);
    rd(1, d); chk("R2 wrap flag sticky", 32'(d[NC]), 1);
    wr(1, 32'(1) << NC);
    rd(1, d); chk("R2 wrap flag cleared by W1C", 32'(d[NC]), 0);

    // register map
    wr(6, 32'h0000_8013);
    rd(6, d); chk("R9 config readback", d, 32'h0000_8013);
    wr(6, 32'h0);
    rd(3, d); chk("R9 unmapped reads zero", d, 0);
    rd(0, d); chk("R9 ctrl reset value", d, 0);

    // sweep: channel x edge mode x source
    for (int c = 0; c < NC; c++) begin
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s <= EW; s++) begin
          wr(4 + c, (32'(1) << 15) | 32'(s << 2) | 32'(m));
          wr(1, 32'h1F);
          // non-selected sources
          @(negedge clk_i); drive_other(c, s, 1'b1);
          repeat (5) @(negedge clk_i); drive_other(c, s, 1'b0);
          repeat (5) @(negedge clk_i);
          rd(1, d); chk("R5 unselected source ignored", 32'(d[c]), 0);
          rd(8 + c, d); chk("R5 measure untouched", d, 32'(exp_meas[c]));
          // rising edge
          e0 = edges; drive_sel(c, s, 1'b1);
          if (m == 1 || m == 3) exp_meas[c] = ((e0 + 2) / 2) % 256;
          exp_hit = (m == 1 || m == 3);
          repeat (5) @(negedge clk_i);
          rd(1, d); chk("R4 flag after rising edge", 32'(d[c]), 32'(exp_hit));
          chk("R8 irq after rising edge", 32'(irq_o), 32'(exp_hit));
          rd(8 + c, d); chk("R6 measure after rising edge", d, 32'(exp_meas[c]));
          if (exp_hit) begin
            wr(1, 32'h0);
            rd(1, d); chk("R7 write 0 keeps flag", 32'(d[c]), 1);
          end
          wr(1, 32'(1) << c);
          rd(1, d); chk("R7 W1C clears flag", 32'(d[c]), 0);
          // falling edge
          @(negedge clk_i);
          e0 = edges; drive_sel(c, s, 1'b0);
          if (m == 2 || m == 3) exp_meas[c] = ((e0 + 2) / 2) % 256;
          exp_hit = (m == 2 || m == 3);
          repeat (5) @(negedge clk_i);
          rd(1, d); chk("R4 flag after falling edge", 32'(d[c]), 32'(exp_hit));
          rd(8 + c, d); chk("R6 measure after falling edge", d, 32'(exp_meas[c]));
          chk_others(c);
        end
      end
      wr(4 + c, 32'h0);
    end

    // interrupt enable gating
    wr(1, 32'h1F);
    wr(5, 32'h0000_0001);
    @(negedge clk_i); cap_pin_i[1] = 1'b1;
    repeat (5) @(negedge clk_i);
    rd(1, d); chk("R7 flag set with irq disabled", 32'(d[1]), 1);
    chk("R8 irq masked", 32'(irq_o), 0);
    wr(5, 32'h0000_8001);
    chk("R8 irq after enable", 32'(irq_o), 1);
    cap_pin_i[1] = 1'b0;
    wr(1, 32'h1F);
    chk("R8 irq drops after clear", 32'(irq_o), 0);

    // external clock source
    wr(0, 32'h1);
    rd(0, d); chk("R9 ctrl readback", d, 1);
    @(negedge clk_i);
    rd(2, c0);
    repeat (10) @(negedge clk_i);
    rd(2, d); chk("R3 no count without ext edges", d, c0);
    for (int p = 0; p < 5; p++) begin
      ext_clk_i = 1'b1; repeat (3) @(negedge clk_i);
      ext_clk_i = 1'b0; repeat (3) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
    rd(2, d); chk("R3 one increment per ext edge", d, (c0 + 5) % 256);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule